// File: doc/BRIEF.md
# Mode-dependent effective address unit

This unit turns the address field of an operand reference into the final word address that goes to memory. Three status bits choose the address rules. The privilege bit selects master or slave. The mapped bit turns page translation on. The extended bit selects real-extended addressing when mapping is off and protected operation when mapping is on. Unmapped plain mode adds in 17 bits and uses the result as a real address. Real-extended mode adds in 20 bits, but the indirect word is still fetched from the low 17-bit region. Mapped mode adds in 17 bits and sends the virtual result through a 256-entry page map into a 20-bit real space.

Each request is one start pulse. The unit may fetch one indirect word over a request/valid read handshake and then adds the index, so indexing is applied after indirection. It reports the result with a single-cycle done pulse. The status-exchange opcode has its own addressing-type bit, and that bit can force a 20-bit real address that skips the map. The unit also flags opcodes that may not run in an interrupt or trap context. The page map is filled through a separate load port.

Top module: `ea_unit`

## Requirements
- R1: With mode_map=0, mode_ext=0 and no forced-real case, index addition wraps modulo 2^17, the indirect word's bits 16:0 form the base, and addr_out[19:17] is 0.
- R2: With mode_map=0 and mode_ext=1 (real-extended), the base (reference field or full 20-bit indirect word) plus the index wraps modulo 2^20. rd_addr for the indirect fetch is the reference field zero-extended, so it lies below 2^17.
- R3: With mode_map=1 and no forced-real case, the 17-bit virtual result va maps to addr_out = {entry[va[16:9]], va[8:0]}. The indirect fetch address is translated the same way from the reference field.
- R4: prot_en is 1 with done exactly when the address was mapped (R3 path), mode_ext=1 and mode_slave=0.
- R5: priv_out reports mode_slave as latched at start. mode_slave has no effect on addr_out or rd_addr.
- R6: An event context exists only when in_event_loc=1 and event_direct=1 together. An event location reached with event_direct=0 is treated as normal code.
- R7: In an event context, illegal_op is raised with done unless the opcode is allowed. Interrupts (event_is_trap=0) allow 7'h0F (status exchange), 7'h0B (status push), 7'h53, 7'h57 and 7'h73 (modify-and-test word/half/byte). Traps allow only 7'h0F and 7'h0B. The address is still produced.
- R8: For opcode 7'h0F with xchg_at=0, the address is a 20-bit real address in every mode and context. It is never mapped, prot_en is 0, and the indirect word is fetched unmapped.
- R9: For opcode 7'h0F with xchg_at=1 in an event context, when the mode is not real-extended, the address follows the R8 rules.
- R10: For opcode 7'h0F with xchg_at=1 in any other case, the normal rules of the current mode (R1 to R3) apply.
- R11: With use_indirect=1, rd_req rises one cycle after start and holds rd_addr until rd_valid. done is a one-cycle pulse, one cycle after start without indirection or one cycle after rd_valid with it, and done and rd_req are never high together.
- R12: A map_we write updates the entry map_idx with map_val on the next edge. The write is ignored in the start cycle and while a request is waiting for its indirect word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one address computation (ignored while busy) |
| mode_slave | input | 1 | Privilege: 0 master, 1 slave |
| mode_map | input | 1 | Page mapping enable |
| mode_ext | input | 1 | Real-extended (unmapped) or protected (mapped) |
| opcode | input | 7 | Opcode of the referencing instruction |
| xchg_at | input | 1 | Addressing-type bit of the status-exchange opcode |
| in_event_loc | input | 1 | Instruction sits in an interrupt or trap location |
| event_direct | input | 1 | Instruction executes as a direct result of the event |
| event_is_trap | input | 1 | Event kind: 1 trap, 0 interrupt |
| ref_addr | input | 17 | Reference address field |
| index_val | input | 20 | Index register value |
| use_index | input | 1 | Apply the index |
| use_indirect | input | 1 | Fetch one indirect word |
| rd_req | output | 1 | Indirect word read request |
| rd_addr | output | 20 | Indirect word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 20 | Indirect word |
| map_we | input | 1 | Page map entry write |
| map_idx | input | 8 | Page map entry number |
| map_val | input | 11 | Real page number (address bits 19:9) |
| done | output | 1 | Final address valid (one cycle) |
| addr_out | output | 20 | Final real address |
| prot_en | output | 1 | Access protection enable |
| priv_out | output | 1 | Latched privilege bit |
| illegal_op | output | 1 | Opcode not allowed in the event context |

## Verification
A page-map load can arrive while a translation is using the map: in the start cycle, or while an indirect word is pending. The bench provokes this by driving map_we at the entries the running request will read, with fresh random values. The result must match the bench's shadow map, which does not take those writes. A second overlap is an illegal event opcode that still needs mapped or forced-real addressing, and the address, illegal_op and prot_en are all judged on the same done pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int VA_W  = 17;
    localparam int RA_W  = 20;
    localparam int PG_W  = 9;
    localparam int MI_W  = VA_W - PG_W;
    localparam int ME_W  = RA_W - PG_W;
    localparam int OP_W  = 7;

    localparam logic [OP_W-1:0] OP_XCHG = 7'h0F;
    localparam logic [OP_W-1:0] OP_PUSH = 7'h0B;
    localparam logic [OP_W-1:0] OP_MODW = 7'h53;
    localparam logic [OP_W-1:0] OP_MODH = 7'h57;
    localparam logic [OP_W-1:0] OP_MODB = 7'h73;

    typedef struct packed {
        logic            busy;
        logic            rd_req;
        logic [RA_W-1:0] rd_addr;
        logic            done;
        logic [RA_W-1:0] addr;
        logic            prot;
        logic            priv;
        logic            illegal;
        logic            mapped;
        logic            ext;
        logic            real20;
        logic            use_idx;
        logic [RA_W-1:0] idx;
    } ea_state_t;
endpackage

// File: rtl/ea_op_legal.sv
module ea_op_legal
    import ea_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic            in_loc,
    input  logic            direct,
    input  logic            is_trap,
    output logic            ctx,
    output logic            is_xchg,
    output logic            illegal
);
    logic ok_trap, ok_int;

    always_comb begin
        is_xchg = (opcode == OP_XCHG);
        ctx     = in_loc && direct;
        ok_trap = is_xchg || (opcode == OP_PUSH);
        ok_int  = ok_trap || (opcode == OP_MODW) || (opcode == OP_MODH)
                  || (opcode == OP_MODB);
        illegal = ctx && !(is_trap ? ok_trap : ok_int);
    end
endmodule

// File: rtl/ea_addr_sum.sv
module ea_addr_sum #(
    parameter int VA_W = 17,
    parameter int RA_W = 20
) (
    input  logic [RA_W-1:0] base,
    input  logic [RA_W-1:0] idx,
    input  logic            use_idx,
    input  logic            wide,
    output logic [RA_W-1:0] sum
);
    logic [RA_W-1:0] add_w;
    logic [VA_W-1:0] add_n;

    always_comb begin
        add_w = base + (use_idx ? idx : '0);
        add_n = base[VA_W-1:0] + (use_idx ? idx[VA_W-1:0] : '0);
        sum   = wide ? add_w : {{(RA_W-VA_W){1'b0}}, add_n};
    end
endmodule

// File: rtl/ea_page_map.sv
module ea_page_map #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] ent_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_val;
        end
    end

    assign rd_val = ent_q[rd_idx];
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode_slave,
    input  logic            mode_map,
    input  logic            mode_ext,
    input  logic [OP_W-1:0] opcode,
    input  logic            xchg_at,
    input  logic            in_event_loc,
    input  logic            event_direct,
    input  logic            event_is_trap,
    input  logic [VA_W-1:0] ref_addr,
    input  logic [RA_W-1:0] index_val,
    input  logic            use_index,
    input  logic            use_indirect,
    output logic            rd_req,
    output logic [RA_W-1:0] rd_addr,
    input  logic            rd_valid,
    input  logic [RA_W-1:0] rd_data,
    input  logic            map_we,
    input  logic [MI_W-1:0] map_idx,
    input  logic [ME_W-1:0] map_val,
    output logic            done,
    output logic [RA_W-1:0] addr_out,
    output logic            prot_en,
    output logic            priv_out,
    output logic            illegal_op
);
    ea_state_t st_d, st_q;

    logic            ctx, is_xchg, illegal_in, real20_in;
    logic            sel_map, sel_ext, sel_real20, sel_use_idx;
    logic [RA_W-1:0] sel_idx, base, sum, ref_ext, xlat;
    logic            wide, eff_map, pm_we;
    logic [VA_W-1:0] lu_va;
    logic [ME_W-1:0] pm_val;

    // exposed to the bound checker
    logic lat_map, lat_ext, lat_real20;

    ea_op_legal u_legal (
        .opcode  (opcode),
        .in_loc  (in_event_loc),
        .direct  (event_direct),
        .is_trap (event_is_trap),
        .ctx     (ctx),
        .is_xchg (is_xchg),
        .illegal (illegal_in)
    );

    ea_addr_sum #(.VA_W(VA_W), .RA_W(RA_W)) u_sum (
        .base    (base),
        .idx     (sel_idx),
        .use_idx (sel_use_idx),
        .wide    (wide),
        .sum     (sum)
    );

    ea_page_map #(.IDX_W(MI_W), .ENT_W(ME_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pm_we),
        .wr_idx (map_idx),
        .wr_val (map_val),
        .rd_idx (lu_va[VA_W-1:PG_W]),
        .rd_val (pm_val)
    );

    always_comb begin
        // forced 20-bit real address for the status-exchange opcode (R8, R9)
        real20_in   = is_xchg && (!xchg_at || (ctx && !(!mode_map && mode_ext)));

        sel_map     = st_q.busy ? st_q.mapped  : mode_map;
        sel_ext     = st_q.busy ? st_q.ext     : mode_ext;
        sel_real20  = st_q.busy ? st_q.real20  : real20_in;
        sel_use_idx = st_q.busy ? st_q.use_idx : use_index;
        sel_idx     = st_q.busy ? st_q.idx     : index_val;

        wide    = sel_real20 || (!sel_map && sel_ext);
        eff_map = sel_map && !sel_real20;

        ref_ext = {{(RA_W-VA_W){1'b0}}, ref_addr};
        base    = st_q.busy ? rd_data : ref_ext;
        lu_va   = (!st_q.busy && use_indirect) ? ref_addr : sum[VA_W-1:0];
        xlat    = {pm_val, lu_va[PG_W-1:0]};

        pm_we   = map_we && !start && !st_q.busy;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (!st_q.busy && start) begin
            st_d.priv    = mode_slave;
            st_d.illegal = illegal_in;
            st_d.mapped  = mode_map;
            st_d.ext     = mode_ext;
            st_d.real20  = real20_in;
            st_d.use_idx = use_index;
            st_d.idx     = index_val;
            st_d.prot    = eff_map && sel_ext && !mode_slave;
            if (use_indirect) begin
                st_d.busy    = 1'b1;
                st_d.rd_req  = 1'b1;
                st_d.rd_addr = eff_map ? xlat : ref_ext;
            end else begin
                st_d.done = 1'b1;
                st_d.addr = eff_map ? xlat : sum;
            end
        end else if (st_q.busy && rd_valid) begin
            st_d.busy   = 1'b0;
            st_d.rd_req = 1'b0;
            st_d.done   = 1'b1;
            st_d.addr   = eff_map ? xlat : sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_req     = st_q.rd_req;
    assign rd_addr    = st_q.rd_addr;
    assign done       = st_q.done;
    assign addr_out   = st_q.addr;
    assign prot_en    = st_q.prot;
    assign priv_out   = st_q.priv;
    assign illegal_op = st_q.illegal;
    assign lat_map    = st_q.mapped;
    assign lat_ext    = st_q.ext;
    assign lat_real20 = st_q.real20;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
    import ea_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            rd_req,
    input logic [RA_W-1:0] rd_addr,
    input logic            rd_valid,
    input logic            done,
    input logic [RA_W-1:0] addr_out,
    input logic            prot_en,
    input logic            priv_out,
    input logic            lat_map,
    input logic            lat_ext,
    input logic            lat_real20
);
    p_unmapped_17_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && !lat_map && !lat_ext && !lat_real20 |-> addr_out[RA_W-1:VA_W] == '0);

    p_ind_fetch_17_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !lat_map && !lat_real20 |-> rd_addr[RA_W-1:VA_W] == '0);

    p_prot_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && prot_en |-> lat_map && lat_ext && !priv_out);

    p_real_unprot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && lat_real20 |-> !prot_en);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

    p_no_done_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !done);
endmodule

bind ea_unit ea_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .done       (done),
    .addr_out   (addr_out),
    .prot_en    (prot_en),
    .priv_out   (priv_out),
    .lat_map    (lat_map),
    .lat_ext    (lat_ext),
    .lat_real20 (lat_real20)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, mode_slave = 1'b0, mode_map = 1'b0, mode_ext = 1'b0;
    logic [6:0]  opcode = '0;
    logic        xchg_at = 1'b0, in_event_loc = 1'b0, event_direct = 1'b0, event_is_trap = 1'b0;
    logic [16:0] ref_addr = '0;
    logic [19:0] index_val = '0;
    logic        use_index = 1'b0, use_indirect = 1'b0;
    logic        rd_req;
    logic [19:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [19:0] rd_data = '0;
    logic        map_we = 1'b0;
    logic [7:0]  map_idx = '0;
    logic [10:0] map_val = '0;
    logic        done, prot_en, priv_out, illegal_op;
    logic [19:0] addr_out;

    int n_chk = 0, n_fail = 0;
    logic [10:0] mm [256];

    // stimulus for one request
    logic        s_slave, s_map, s_ext, s_at, s_loc, s_dir, s_trap, s_useidx, s_ind, s_clash;
    logic [6:0]  s_op;
    logic [16:0] s_ref;
    logic [19:0] s_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] xl(input logic [16:0] va);
        return {mm[va[16:9]], va[8:0]};
    endfunction

    function automatic logic [19:0] mem_word(input logic [19:0] a);
        logic [31:0] t;
        t = a * 32'h0009E37 + 32'h000A1F3;
        return t[19:0] ^ {a[9:0], a[19:10]};
    endfunction

    task automatic load_map(input logic [7:0] i, input logic [10:0] v);
        @(negedge clk);
        map_we = 1'b1; map_idx = i; map_val = v;
        @(negedge clk);
        map_we = 1'b0;
        mm[i] = v;
    endtask

    task automatic apply();
        logic ctx, xchg, real20, wide, emap, eprot, eill, okt, oki, got, served, seen;
        logic [19:0] eind, word, base, iv, sum, efin;
        string tag;
        int wcnt;
        ctx    = s_loc && s_dir;
        xchg   = (s_op == 7'h0F);
        real20 = xchg && (!s_at || (ctx && !(!s_map && s_ext)));
        wide   = real20 || (!s_map && s_ext);
        emap   = s_map && !real20;
        eind   = emap ? xl(s_ref) : {3'b0, s_ref};
        word   = mem_word(eind);
        base   = s_ind ? word : {3'b0, s_ref};
        iv     = s_useidx ? s_idx : 20'd0;
        sum    = wide ? base + iv : {3'b0, 17'(base[16:0] + iv[16:0])};
        efin   = emap ? xl(sum[16:0]) : sum;
        eprot  = emap && s_ext && !s_slave;
        okt    = xchg || (s_op == 7'h0B);
        oki    = okt || (s_op == 7'h53) || (s_op == 7'h57) || (s_op == 7'h73);
        eill   = ctx && !(s_trap ? okt : oki);
        if (s_clash)                 tag = "R12";
        else if (xchg && !s_at)      tag = "R8";
        else if (real20)             tag = "R9";
        else if (xchg)               tag = "R10";
        else if (s_map)              tag = "R3";
        else if (s_ext)              tag = "R2";
        else                         tag = "R1";
        wcnt = $urandom_range(0, 3);

        @(negedge clk);
        start = 1'b1; mode_slave = s_slave; mode_map = s_map; mode_ext = s_ext;
        opcode = s_op; xchg_at = s_at; in_event_loc = s_loc; event_direct = s_dir;
        event_is_trap = s_trap; ref_addr = s_ref; index_val = s_idx;
        use_index = s_useidx; use_indirect = s_ind;
        if (s_clash) begin
            map_we = 1'b1; map_idx = s_ref[16:9]; map_val = 11'($urandom);
        end
        @(negedge clk);
        start = 1'b0; map_we = 1'b0;
        got = 1'b0; served = 1'b0; seen = 1'b0;
        for (int cyc = 0; cyc < 40 && !got; cyc++) begin
            if (done) begin
                got = 1'b1;
                check(tag, 32'(addr_out), 32'(efin));
                check("R4", 32'(prot_en), 32'(eprot));
                check("R5", 32'(priv_out), 32'(s_slave));
                check((s_loc && !s_dir) ? "R6" : "R7", 32'(illegal_op), 32'(eill));
                check("R11", 32'(served), 32'(s_ind));
            end else begin
                if (rd_req && !served) begin
                    if (!seen) begin
                        seen = 1'b1;
                        check(tag, 32'(rd_addr), 32'(eind));
                    end
                    if (wcnt == 0) begin
                        rd_valid = 1'b1; rd_data = word; served = 1'b1;
                    end else wcnt--;
                end
                if (s_clash) begin
                    map_we = 1'b1; map_idx = sum[16:9]; map_val = 11'($urandom);
                end
                @(negedge clk);
                rd_valid = 1'b0; map_we = 1'b0;
            end
        end
        check("R11", 32'(got), 32'd1);
        @(negedge clk);
        check("R11", 32'(done), 32'd0);
    endtask

    task automatic clear_stim();
        s_slave = 0; s_map = 0; s_ext = 0; s_at = 0; s_loc = 0; s_dir = 0; s_trap = 0;
        s_useidx = 0; s_ind = 0; s_clash = 0; s_op = 7'h20; s_ref = '0; s_idx = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd20250);
        for (int i = 0; i < 256; i++) mm[i] = '0;
        repeat (3) @(negedge clk);
        check("R11", 32'(done), 32'd0);
        check("R11", 32'(rd_req), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) load_map(8'(i), 11'($urandom));

        // R1: 17-bit wrap
        clear_stim(); s_ref = 17'h1FFFF; s_idx = 20'h00001; s_useidx = 1; apply();
        // R1: indirect word high bits dropped
        clear_stim(); s_ref = 17'h00123; s_ind = 1; s_useidx = 1; s_idx = 20'hFFFFF; apply();
        // R2: real-extended carries into bit 17
        clear_stim(); s_ext = 1; s_ref = 17'h1FFFF; s_idx = 20'h00001; s_useidx = 1; apply();
        clear_stim(); s_ext = 1; s_ref = 17'h1ABCD; s_ind = 1; s_useidx = 1; s_idx = 20'h40000; apply();
        // R3/R4: mapped, master protected and slave
        clear_stim(); s_map = 1; s_ref = 17'h0F00F; s_ind = 1; s_useidx = 1; s_idx = 20'h00321; apply();
        clear_stim(); s_map = 1; s_ext = 1; s_ref = 17'h12345; apply();
        clear_stim(); s_map = 1; s_ext = 1; s_slave = 1; s_ref = 17'h12345; apply();
        // R8: AT=0 forces real even when mapped
        clear_stim(); s_map = 1; s_ext = 1; s_op = 7'h0F; s_ref = 17'h13579; s_ind = 1; apply();
        // R9 / R10
        clear_stim(); s_map = 1; s_op = 7'h0F; s_at = 1; s_loc = 1; s_dir = 1; s_ref = 17'h0AAAA; apply();
        clear_stim(); s_ext = 1; s_op = 7'h0F; s_at = 1; s_loc = 1; s_dir = 1; s_ref = 17'h0AAAA; apply();
        clear_stim(); s_map = 1; s_op = 7'h0F; s_at = 1; s_loc = 1; s_dir = 0; s_ref = 17'h0AAAA; apply();
        // R6 / R7
        clear_stim(); s_op = 7'h22; s_loc = 1; s_dir = 1; apply();
        clear_stim(); s_op = 7'h22; s_loc = 1; s_dir = 0; apply();
        clear_stim(); s_op = 7'h53; s_loc = 1; s_dir = 1; s_trap = 1; s_map = 1; apply();
        clear_stim(); s_op = 7'h57; s_loc = 1; s_dir = 1; s_trap = 0; apply();
        // R12: map write clashes with a running translation
        clear_stim(); s_map = 1; s_ref = 17'h1C0DE; s_ind = 1; s_clash = 1; apply();

        for (int k = 0; k < 400; k++) begin
            s_slave = 1'($urandom); s_map = 1'($urandom); s_ext = 1'($urandom);
            s_at = 1'($urandom); s_loc = 1'($urandom); s_dir = 1'($urandom);
            s_trap = 1'($urandom); s_useidx = 1'($urandom); s_ind = 1'($urandom);
            s_clash = ($urandom_range(0, 5) == 0);
            case ($urandom_range(0, 6))
                0: s_op = 7'h0F; 1: s_op = 7'h0B; 2: s_op = 7'h53;
                3: s_op = 7'h57; 4: s_op = 7'h73; 5: s_op = 7'h0F;
                default: s_op = 7'($urandom);
            endcase
            s_ref = 17'($urandom); s_idx = 20'($urandom);
            apply();
            if (k % 8 == 0) load_map(8'($urandom), 11'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule